// File: doc/BRIEF.md
# Seconds and Nanoseconds Time Base

This block is a free-running time-of-day counter. Time is held in real units: a whole-second count and a nanosecond remainder. On every bus clock the remainder grows by a fixed step. That step is the bus clock period in nanoseconds and is set when the block is built. When the remainder reaches one full second, it wraps and the second count advances.

Software reads the time through a small read-only register window. There is one register for each of these:

- the clock period, so that software can derive tick rates;
- the high half of the second count;
- the low half of the second count;
- the nanosecond remainder.

The seconds and nanoseconds always change together on the same clock edge. Because of this, software gets a consistent time by reading the low seconds half, then the nanoseconds, then the low seconds half again. If the two low-half reads differ, it repeats the sequence. Write strobes reach the block but change nothing.

Top module: `secNsTimebase`

## Requirements
- R1: While reset is asserted, the seconds and the nanosecond field are zero, and every register reads zero except the period register.
- R2: The period register at byte offset 0x18 reads the build-time step `PERIOD_NS`, zero-extended. The step is allowed from 1 to 1000.
- R3: The nanosecond field always stays below `WRAP_NS`, which defaults to 1,000,000,000.
- R4: On every clock edge out of reset, the nanosecond field grows by `PERIOD_NS`. When the sum is `WRAP_NS` or more, `WRAP_NS` is taken off the sum.
- R5: The second count (2×`DATA_W` bits) goes up by exactly one on the edge where the nanosecond field wraps, and holds on every other edge.
- R6: The high second half reads at offset 0x20 and the low half at offset 0x24. When the low half rolls from all ones to zero, the high half goes up by one on that same edge.
- R7: The nanosecond field reads at offset 0x28, zero-extended.
- R8: Any offset other than 0x18, 0x20, 0x24 or 0x28 reads zero.
- R9: Asserting `wrEn` with any `wrData`, at any offset, changes neither the time nor any read value.
- R10: Read the low half, then the nanoseconds, then the low half again. If the two low-half reads match, then (low half × `WRAP_NS` + nanoseconds) equals the elapsed time at the nanosecond read, modulo the low-half range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | Byte offset of the register being read |
| rdData | output | DATA_W | Read data for `addr`; combinational |
| wrEn | input | 1 | Write strobe; ignored |
| wrData | input | DATA_W | Write data; ignored |

## Verification
The nanosecond wrap and the seconds carry fall on the same edge. With a narrow seconds half, a low-half rollover from all ones into the high half also falls on that edge. The bench builds the block with an 8-bit data width, a 20 ns second and a 7 ns step, so every wrap pattern recurs quickly. The run passes through the low-half rollover twice. On the exact cycle where the arithmetic model predicts a rollover, the bench reads the high half and compares both halves against the model.

// File: rtl/secNsTimebase_pkg.sv
package secNsTimebase_pkg;

  localparam logic [7:0] OFS_PERIOD = 8'h18;
  localparam logic [7:0] OFS_SEC_HI = 8'h20;
  localparam logic [7:0] OFS_SEC_LO = 8'h24;
  localparam logic [7:0] OFS_NSEC   = 8'h28;

  typedef struct packed {
    logic secTick;
    logic selPeriod;
    logic selSecHi;
    logic selSecLo;
    logic selNsec;
  } tbStrobe_t;

endpackage

// File: rtl/tbNsCtrl.sv
module tbNsCtrl
  import secNsTimebase_pkg::*;
#(
  parameter int PERIOD_NS = 20,
  parameter int WRAP_NS   = 1000000000,
  parameter int ADDR_W    = 8,
  parameter int NS_W      = $clog2(WRAP_NS + PERIOD_NS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  output logic [NS_W-1:0]   nsec,
  output tbStrobe_t         strobe
);

  localparam logic [NS_W-1:0] STEP = NS_W'(PERIOD_NS);
  localparam logic [NS_W-1:0] WRAP = NS_W'(WRAP_NS);

  logic [NS_W-1:0] nsQ;
  logic [NS_W-1:0] nsSum;
  logic            wrapHit;

  always_comb begin
    nsSum   = nsQ + STEP;
    wrapHit = (nsSum >= WRAP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nsQ <= '0;
    else if (wrapHit) nsQ <= nsSum - WRAP;
    else nsQ <= nsSum;
  end

  always_comb begin
    strobe.secTick   = wrapHit;
    strobe.selPeriod = (addr == ADDR_W'(OFS_PERIOD));
    strobe.selSecHi  = (addr == ADDR_W'(OFS_SEC_HI));
    strobe.selSecLo  = (addr == ADDR_W'(OFS_SEC_LO));
    strobe.selNsec   = (addr == ADDR_W'(OFS_NSEC));
  end

  assign nsec = nsQ;

endmodule

// File: rtl/tbSecPath.sv
module tbSecPath
  import secNsTimebase_pkg::*;
#(
  parameter int PERIOD_NS = 20,
  parameter int DATA_W    = 32,
  parameter int NS_W      = 30
) (
  input  logic              clk,
  input  logic              rstN,
  input  tbStrobe_t         strobe,
  input  logic [NS_W-1:0]   nsec,
  output logic [DATA_W-1:0] secLo,
  output logic [DATA_W-1:0] secHi,
  output logic [DATA_W-1:0] rdData
);

  localparam logic [DATA_W-1:0] PERIOD_VAL = DATA_W'(PERIOD_NS);

  logic [DATA_W-1:0] loQ;
  logic [DATA_W-1:0] hiQ;
  logic              loFull;

  assign loFull = &loQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loQ <= '0;
      hiQ <= '0;
    end else if (strobe.secTick) begin
      loQ <= loQ + 1'b1;
      if (loFull) hiQ <= hiQ + 1'b1;
    end
  end

  generate
    if (NS_W < DATA_W) begin : g_nsPad
      logic [DATA_W-1:0] nsWide;
      assign nsWide = {{(DATA_W - NS_W){1'b0}}, nsec};
      always_comb begin
        rdData = '0;
        if (strobe.selPeriod) rdData = PERIOD_VAL;
        if (strobe.selSecHi)  rdData = hiQ;
        if (strobe.selSecLo)  rdData = loQ;
        if (strobe.selNsec)   rdData = nsWide;
      end
    end else begin : g_nsFull
      always_comb begin
        rdData = '0;
        if (strobe.selPeriod) rdData = PERIOD_VAL;
        if (strobe.selSecHi)  rdData = hiQ;
        if (strobe.selSecLo)  rdData = loQ;
        if (strobe.selNsec)   rdData = nsec[DATA_W-1:0];
      end
    end
  endgenerate

  assign secLo = loQ;
  assign secHi = hiQ;

endmodule

// File: rtl/secNsTimebase.sv
module secNsTimebase
  import secNsTimebase_pkg::*;
#(
  parameter int PERIOD_NS = 20,
  parameter int WRAP_NS   = 1000000000,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] rdData,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData
);

  localparam int NS_W = $clog2(WRAP_NS + PERIOD_NS);

  generate
    if (PERIOD_NS < 1 || PERIOD_NS > 1000 || NS_W > DATA_W) begin : g_badCfg
      $error("secNsTimebase: unsupported period or width");
    end
  endgenerate

  tbStrobe_t         strobe;
  logic [NS_W-1:0]   nsecQ;
  logic [DATA_W-1:0] secLoQ;
  logic [DATA_W-1:0] secHiQ;
  logic              unusedWrite;

  assign unusedWrite = ^{wrEn, wrData};

  tbNsCtrl #(
    .PERIOD_NS(PERIOD_NS),
    .WRAP_NS  (WRAP_NS),
    .ADDR_W   (ADDR_W),
    .NS_W     (NS_W)
  ) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .addr  (addr),
    .nsec  (nsecQ),
    .strobe(strobe)
  );

  tbSecPath #(
    .PERIOD_NS(PERIOD_NS),
    .DATA_W   (DATA_W),
    .NS_W     (NS_W)
  ) u_path (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .nsec  (nsecQ),
    .secLo (secLoQ),
    .secHi (secHiQ),
    .rdData(rdData)
  );

endmodule

// File: rtl/tbTimebaseChk.sv
module tbTimebaseChk
  import secNsTimebase_pkg::*;
#(
  parameter int PERIOD_NS = 20,
  parameter int WRAP_NS   = 1000000000,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int NS_W      = $clog2(WRAP_NS + PERIOD_NS)
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] rdData,
  input logic              wrEn,
  input logic [NS_W-1:0]   nsec,
  input logic [DATA_W-1:0] secLo,
  input logic [DATA_W-1:0] secHi
);

  logic [NS_W:0]       nsNext;
  logic [2*DATA_W-1:0] secAll;
  logic                mapped;

  assign nsNext = {1'b0, nsec} + (NS_W+1)'(PERIOD_NS);
  assign secAll = {secHi, secLo};
  assign mapped = (addr == ADDR_W'(OFS_PERIOD)) || (addr == ADDR_W'(OFS_SEC_HI)) ||
                  (addr == ADDR_W'(OFS_SEC_LO)) || (addr == ADDR_W'(OFS_NSEC));

  AST_NS_BELOW_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    {1'b0, nsec} < (NS_W+1)'(WRAP_NS)); // R3

  AST_NS_STEP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ($past(nsNext) >= (NS_W+1)'(WRAP_NS))
             ? ({1'b0, nsec} == $past(nsNext) - (NS_W+1)'(WRAP_NS))
             : ({1'b0, nsec} == $past(nsNext))); // R4

  AST_SEC_ON_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> secAll == $past(secAll) +
             (2*DATA_W)'($past(nsNext) >= (NS_W+1)'(WRAP_NS))); // R5

  AST_HI_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    (secLo == '0 && $past(secLo) == '1) |-> secHi == $past(secHi) + 1'b1); // R6

  AST_PERIOD_READ: assert property (@(posedge clk) disable iff (!rstN)
    addr == ADDR_W'(OFS_PERIOD) |-> rdData == DATA_W'(PERIOD_NS)); // R2

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !mapped |-> rdData == '0); // R8

  AST_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (secLo == $past(secLo)) || (secLo == $past(secLo) + 1'b1)); // R9

endmodule

bind secNsTimebase tbTimebaseChk #(
  .PERIOD_NS(PERIOD_NS),
  .WRAP_NS  (WRAP_NS),
  .DATA_W   (DATA_W),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .addr  (addr),
  .rdData(rdData),
  .wrEn  (wrEn),
  .nsec  (nsecQ),
  .secLo (secLoQ),
  .secHi (secHiQ)
);

// File: tb/secNsTimebase_bench.sv
`timescale 1ns/1ps
module secNsTimebase_bench;

  localparam int PER  = 7;
  localparam int WRAP = 20;
  localparam int DW   = 8;
  localparam int AW   = 8;
  localparam longint LO_RANGE = 256;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] rdData;
  logic          wrEn = 1'b0;
  logic [DW-1:0] wrData = '0;

  int     errors = 0;
  int     checks = 0;
  longint n = 0;
  bit     finished = 1'b0;

  always #10 clk = ~clk;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) n <= 0;
    else n <= n + 1;
  end

  secNsTimebase #(
    .PERIOD_NS(PER), .WRAP_NS(WRAP), .DATA_W(DW), .ADDR_W(AW)
  ) u_secNsTimebase (
    .clk(clk), .rstN(rstN), .addr(addr), .rdData(rdData),
    .wrEn(wrEn), .wrData(wrData)
  );

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h actual=%0d expected=%0d", req, addr, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    longint total, es, ens, prevEs;
    logic [DW-1:0] lo0, lo1, nsv;
    longint nAt;

    // R1 / R2 under reset
    repeat (3) @(negedge clk);
    addr = 8'h20; #1 check("R1 secHi in reset", rdData, 0);
    addr = 8'h24; #1 check("R1 secLo in reset", rdData, 0);
    addr = 8'h28; #1 check("R1 nsec in reset", rdData, 0);
    addr = 8'h18; #1 check("R2 period in reset", rdData, PER);

    @(negedge clk);
    rstN = 1'b1;
    prevEs = 0;

    // Sweep across two low-half rollovers, with writes thrown in (R9)
    for (int i = 0; i < 1500; i++) begin
      @(negedge clk);
      total = n * PER;
      es = total / WRAP;
      ens = total % WRAP;
      if ((es % LO_RANGE) == 0 && es != prevEs) begin
        addr = 8'h20;
      end else begin
        case (i % 6)
          0: addr = 8'h18;
          1: addr = 8'h20;
          2: addr = 8'h24;
          3: addr = 8'h28;
          4: addr = 8'h1C;
          default: addr = 8'(i * 13);
        endcase
      end
      wrEn = (i % 3 == 0);
      wrData = 8'(i * 37);
      #2;
      case (addr)
        8'h18: check("R2 period", rdData, PER);
        8'h20: check("R6 R5 R9 secHi carry", rdData, 8'(es / LO_RANGE));
        8'h24: check("R5 R9 secLo", rdData, 8'(es % LO_RANGE));
        8'h28: check("R4 R3 R7 R9 nsec", rdData, 8'(ens));
        default: check("R8 unmapped", rdData, 0);
      endcase
      prevEs = es;
    end
    wrEn = 1'b0;

    // R10: lo, ns, lo snapshot protocol
    for (int k = 0; k < 40; k++) begin
      @(negedge clk); addr = 8'h24; #2 lo0 = rdData;
      @(negedge clk); addr = 8'h28; #2 nsv = rdData; nAt = n;
      @(negedge clk); addr = 8'h24; #2 lo1 = rdData;
      if (lo0 == lo1)
        check("R10 snapshot", 8'((longint'(lo0) * WRAP + nsv) % 256),
              8'((nAt * PER) % (LO_RANGE * WRAP) % 256));
    end

    // R1: reset mid-run clears time
    @(negedge clk);
    rstN = 1'b0;
    addr = 8'h24; #1 check("R1 secLo after reset", rdData, 0);
    addr = 8'h20; #1 check("R1 secHi after reset", rdData, 0);
    addr = 8'h28; #1 check("R1 nsec after reset", rdData, 0);
    @(negedge clk);
    finish_run();
  end

endmodule